// File: doc/BRIEF.md
# Cycle-by-Cycle Current Limit Gate

This block sits between a PWM modulator and the two gate-drive enables of a synchronous buck power stage. Each clock it decides which switch may conduct. The high-side switch conducts while the modulator asks for on-time. The low-side switch conducts for the rest of the period. Two comparator flags change that decision.

A low-side overcurrent seen during low-side conduction holds off the next high-side turn-on until the valley current falls below the threshold. A high-side overcurrent cuts the on-time at once, but only after a leading-edge blanking window that hides switching noise. After a cut, the high side stays off until the modulator withdraws its request and asks again.

A valley strobe marks each switching-period boundary. At that strobe the block emits a one-cycle low-side event pulse if a low-side limit was seen in the period. This pulse is meant for a downstream hiccup integrator. A separate high-side event pulse is only for observation. A 2-bit level select passes straight through to both comparator threshold inputs. A global off input forces both gates low.

Top module: `ccl_gate`

## Requirements
- R1: While rst_n is low, both gate enables and both event pulses are low.
- R2: gate_off_i high drives both gate enables low in the same cycle, independent of every other input. After gate_off_i falls, the first rising clock edge turns the low-side gate on.
- R3: hs_gate_o and ls_gate_o are never high in the same cycle.
- R4: With the low-side gate on, pwm_req_i high, ls_oc_i low and no high-side lockout, the next rising edge turns the high-side gate on and the low-side gate off.
- R5: While the low-side gate is on and ls_oc_i is high, the high-side gate does not turn on at the next edge, even with pwm_req_i high.
- R6: Once ls_oc_i falls with pwm_req_i still high, the high-side gate turns on at the next rising edge.
- R7: With the high-side gate on, pwm_req_i low at a rising edge switches to the low-side gate. ls_oc_i has no effect while the high-side gate is on.
- R8: hs_oc_i is ignored during the first LEB high-side cycles after each turn-on. The cycle of turn-on counts as the first of these cycles.
- R9: hs_oc_i high in a high-side cycle after blanking switches to the low-side gate at the next edge, and hs_evt_o is high for exactly that one following cycle. The high side then stays off while pwm_req_i remains high, and turns on again only after pwm_req_i has been low at a rising edge.
- R10: LEB equals the blanking time divided by the clock period, rounded up. With the defaults (108000 ps, 5000 ps) LEB is 22.
- R11: ls_evt_o is high for one cycle, in the cycle after valley_stb_i is high. It is high only if ls_oc_i was high in some cycle with the low-side gate on since the previous strobe, including the strobe cycle itself. hs_oc_i never causes it.
- R12: ls_lvl_o and hs_lvl_o both equal lim_sel_i combinationally. Code 0 selects the 2 A rating, code 1 the 3 A rating, code 2 the 4 A rating and code 3 the 5 A rating.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| gate_off_i | input | 1 | Forces both gates off |
| pwm_req_i | input | 1 | Modulator requests high-side on-time |
| valley_stb_i | input | 1 | Switching-period boundary strobe |
| ls_oc_i | input | 1 | Low-side (valley) overcurrent comparator |
| hs_oc_i | input | 1 | High-side (peak) overcurrent comparator |
| lim_sel_i | input | 2 | Current-limit level code |
| hs_gate_o | output | 1 | High-side gate enable |
| ls_gate_o | output | 1 | Low-side gate enable |
| ls_lvl_o | output | 2 | Level code to the low-side comparator |
| hs_lvl_o | output | 2 | Level code to the high-side comparator |
| ls_evt_o | output | 1 | Per-period low-side limit pulse, feeds hiccup logic |
| hs_evt_o | output | 1 | High-side truncation pulse, observation only |

## Verification
The assertions assume that the comparator flags and the modulator request are synchronous to clk. They need no handshake, and a flag may stay high for any number of cycles. They also assume that the strobe is a free input that may coincide with either conduction phase. The stimulus changes every input one time unit after a rising edge and holds it until after the next edge. Each output is therefore a function of one set of sampled inputs. The stimulus keeps hs_oc_i high across the whole blanking window, so that the exact edge of the cut shows which cycle the blanking ends.

// File: rtl/ccl_pkg.sv
package ccl_pkg;

  // Conduction phase of the power stage
  typedef enum logic [1:0] {
    PH_OFF  = 2'd0,
    PH_LOW  = 2'd1,
    PH_HIGH = 2'd2
  } phase_t;

  // Blanking length in clock cycles, rounded up so it is never shorter
  // than the requested time.
  function automatic int leb_cycles(input int blank_ps, input int clk_ps);
    return (blank_ps + clk_ps - 1) / clk_ps;
  endfunction

  // A low-side hit counts only while the low-side gate is conducting
  function automatic logic ls_hit(input logic ls_on, input logic ls_oc);
    return ls_on & ls_oc;
  endfunction

endpackage

// File: rtl/ccl_blank_timer.sv
module ccl_blank_timer #(
  parameter int LEB = 22
) (
  input  logic clk,
  input  logic rst_n,
  input  logic hs_start,
  input  logic hs_on,
  output logic blank_active
);

  generate
    if (LEB == 0) begin : g_no_blank
      assign blank_active = 1'b0;
    end else begin : g_blank
      localparam int CNT_W = $clog2(LEB + 1);
      logic [CNT_W-1:0] cnt_q;

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          cnt_q <= '0;
        end else if (hs_start) begin
          cnt_q <= CNT_W'(LEB);
        end else if (!hs_on) begin
          cnt_q <= '0;
        end else if (cnt_q != '0) begin
          cnt_q <= cnt_q - 1'b1;
        end
      end

      assign blank_active = (cnt_q != '0);

      AST_BLANK_ARMED: assert property (@(posedge clk) disable iff (!rst_n)
        hs_start |=> blank_active); // R10
    end
  endgenerate

endmodule

// File: rtl/ccl_phase_fsm.sv
module ccl_phase_fsm
  import ccl_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   gate_off,
  input  logic   pwm_req,
  input  logic   ls_oc,
  input  logic   hs_oc,
  input  logic   blank_active,
  output phase_t phase,
  output logic   hs_start,
  output logic   hs_trunc
);

  phase_t phase_q, phase_d;
  logic   lock_q;

  always_comb begin
    phase_d  = phase_q;
    hs_start = 1'b0;
    hs_trunc = 1'b0;
    if (gate_off) begin
      phase_d = PH_OFF;
    end else begin
      case (phase_q)
        PH_OFF:  phase_d = PH_LOW;
        PH_LOW: begin
          if (pwm_req && !ls_oc && !lock_q) begin
            phase_d  = PH_HIGH;
            hs_start = 1'b1;
          end
        end
        PH_HIGH: begin
          if (hs_oc && !blank_active) begin
            phase_d  = PH_LOW;
            hs_trunc = 1'b1;
          end else if (!pwm_req) begin
            phase_d = PH_LOW;
          end
        end
        default: phase_d = PH_OFF;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_OFF;
      lock_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      if (hs_trunc)      lock_q <= 1'b1;
      else if (!pwm_req) lock_q <= 1'b0;
    end
  end

  assign phase = phase_q;

  AST_OFF_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    gate_off |=> phase_q == PH_OFF); // R2
  AST_LS_OC_INHIBIT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_LOW && ls_oc) |=> phase_q != PH_HIGH); // R5
  AST_BLANK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HIGH && blank_active && pwm_req && !gate_off) |=> phase_q == PH_HIGH); // R8
  AST_HS_CUT: assert property (@(posedge clk) disable iff (!rst_n)
    (phase_q == PH_HIGH && !blank_active && hs_oc && !gate_off) |=> phase_q == PH_LOW); // R9
  AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && pwm_req && phase_q == PH_LOW) |=> phase_q != PH_HIGH); // R9

endmodule

// File: rtl/ccl_event_track.sv
module ccl_event_track
  import ccl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic ls_on,
  input  logic ls_oc,
  input  logic valley_stb,
  input  logic hs_trunc,
  output logic ls_evt,
  output logic hs_evt
);

  logic seen_q;
  logic hit_now;

  assign hit_now = ls_hit(ls_on, ls_oc);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      ls_evt <= 1'b0;
      hs_evt <= 1'b0;
    end else begin
      hs_evt <= hs_trunc;
      if (valley_stb) begin
        ls_evt <= seen_q | hit_now;
        seen_q <= 1'b0;
      end else begin
        ls_evt <= 1'b0;
        seen_q <= seen_q | hit_now;
      end
    end
  end

  AST_LS_EVT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    ls_evt |-> $past(valley_stb)); // R11
  AST_HS_EVT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    hs_evt |=> !hs_evt); // R9

endmodule

// File: rtl/ccl_gate.sv
module ccl_gate
  import ccl_pkg::*;
#(
  parameter int CLK_PERIOD_PS = 5000,
  parameter int LEB_PS        = 108000,
  parameter int LVL_W         = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             gate_off_i,
  input  logic             pwm_req_i,
  input  logic             valley_stb_i,
  input  logic             ls_oc_i,
  input  logic             hs_oc_i,
  input  logic [LVL_W-1:0] lim_sel_i,
  output logic             hs_gate_o,
  output logic             ls_gate_o,
  output logic [LVL_W-1:0] ls_lvl_o,
  output logic [LVL_W-1:0] hs_lvl_o,
  output logic             ls_evt_o,
  output logic             hs_evt_o
);

  localparam int LEB = leb_cycles(LEB_PS, CLK_PERIOD_PS);

  phase_t phase;
  logic   hs_start;
  logic   hs_trunc;
  logic   blank_active;

  ccl_phase_fsm u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .gate_off     (gate_off_i),
    .pwm_req      (pwm_req_i),
    .ls_oc        (ls_oc_i),
    .hs_oc        (hs_oc_i),
    .blank_active (blank_active),
    .phase        (phase),
    .hs_start     (hs_start),
    .hs_trunc     (hs_trunc)
  );

  ccl_blank_timer #(.LEB(LEB)) u_blank (
    .clk          (clk),
    .rst_n        (rst_n),
    .hs_start     (hs_start),
    .hs_on        (phase == PH_HIGH),
    .blank_active (blank_active)
  );

  assign hs_gate_o = (phase == PH_HIGH) & ~gate_off_i;
  assign ls_gate_o = (phase == PH_LOW)  & ~gate_off_i;

  ccl_event_track u_evt (
    .clk        (clk),
    .rst_n      (rst_n),
    .ls_on      (ls_gate_o),
    .ls_oc      (ls_oc_i),
    .valley_stb (valley_stb_i),
    .hs_trunc   (hs_trunc),
    .ls_evt     (ls_evt_o),
    .hs_evt     (hs_evt_o)
  );

  // Both comparators take the same code; the high-side one scales it
  assign ls_lvl_o = lim_sel_i;
  assign hs_lvl_o = lim_sel_i;

  AST_OFF_GATES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (gate_off_i && $past(gate_off_i)) |-> !(hs_gate_o || ls_gate_o)); // R2

endmodule

// File: tb/ccl_gate_tb_top.sv
module ccl_gate_tb_top;

  localparam int CLK_PS   = 5000;
  localparam int BLANK_PS = 108000;
  localparam int LEB_EXP  = (BLANK_PS / CLK_PS) + ((BLANK_PS % CLK_PS) != 0 ? 1 : 0);

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gate_off = 1'b0, pwm = 1'b0, vs = 1'b0, lso = 1'b0, hso = 1'b0;
  logic [1:0] sel = 2'd0;
  logic       hs_g, ls_g, ls_e, hs_e;
  logic [1:0] ls_lvl, hs_lvl;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ccl_gate #(.CLK_PERIOD_PS(CLK_PS), .LEB_PS(BLANK_PS), .LVL_W(2)) dut_i (
    .clk(clk), .rst_n(rst_n), .gate_off_i(gate_off), .pwm_req_i(pwm),
    .valley_stb_i(vs), .ls_oc_i(lso), .hs_oc_i(hso), .lim_sel_i(sel),
    .hs_gate_o(hs_g), .ls_gate_o(ls_g), .ls_lvl_o(ls_lvl), .hs_lvl_o(hs_lvl),
    .ls_evt_o(ls_e), .hs_evt_o(hs_e)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic outs4(input string req, input logic [3:0] exp);
    logic [3:0] act;
    act = {hs_g, ls_g, ls_e, hs_e};
    chk(act == exp, req, act, exp);
    chk(!(hs_g && ls_g), "R3", {hs_g, ls_g}, 2'b00);
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  // fields: requirement number, {off,pwm,vs,lso,hso}, expected {hs,ls,lse,hse}
  localparam int NV = 17;
  localparam logic [12:0] VEC [NV] = '{
    {4'd2,  5'b00000, 4'b0100},  // R2 release -> low side
    {4'd5,  5'b01010, 4'b0100},  // R5 valley overcurrent blocks
    {4'd5,  5'b01010, 4'b0100},  // R5
    {4'd6,  5'b01000, 4'b1000},  // R6 clears -> high side
    {4'd11, 5'b01100, 4'b1010},  // R11 strobe reports earlier hit
    {4'd7,  5'b00000, 4'b0100},  // R7 normal off
    {4'd11, 5'b00100, 4'b0100},  // R11 no hit, no pulse
    {4'd11, 5'b00001, 4'b0100},  // R11 high-side flag in low side ignored
    {4'd11, 5'b00100, 4'b0100},  // R11
    {4'd11, 5'b00110, 4'b0110},  // R11 hit in strobe cycle
    {4'd4,  5'b01000, 4'b1000},  // R4 turn-on
    {4'd7,  5'b01010, 4'b1000},  // R7 valley flag ignored in high side
    {4'd11, 5'b01100, 4'b1000},  // R11 no pulse
    {4'd2,  5'b11000, 4'b0000},  // R2 forced off
    {4'd2,  5'b11000, 4'b0000},  // R2
    {4'd2,  5'b01000, 4'b0100},  // R2 release -> low side first
    {4'd4,  5'b01000, 4'b1000}   // R4
  };

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int cnt;
    // R1 reset state
    pwm = 1'b1; vs = 1'b1; lso = 1'b1;
    repeat (3) tick();
    outs4("R1", 4'b0000);
    pwm = 1'b0; vs = 1'b0; lso = 1'b0;
    tick();
    rst_n = 1'b1;
    #1;

    // R12 level pass-through
    for (int i = 0; i < 4; i++) begin
      sel = 2'(i);
      #1;
      chk(ls_lvl == 2'(i) && hs_lvl == 2'(i), "R12", {ls_lvl, hs_lvl}, {2'(i), 2'(i)});
    end

    // Vector walk
    for (int v = 0; v < NV; v++) begin
      {gate_off, pwm, vs, lso, hso} = VEC[v][8:4];
      tick();
      outs4($sformatf("R%0d", VEC[v][12:9]), VEC[v][3:0]);
    end

    // R2: forced off takes effect within the cycle (currently high side)
    gate_off = 1'b1;
    #1;
    chk(!hs_g && !ls_g, "R2", {hs_g, ls_g}, 2'b00);
    tick();
    gate_off = 1'b0; pwm = 1'b0;
    tick();
    outs4("R2", 4'b0100);

    // R8 / R10: blanking length, then R9 truncation
    pwm = 1'b1; hso = 1'b1;
    tick();
    cnt = 0;
    while (hs_g && cnt < 100) begin
      cnt++;
      tick();
    end
    chk(cnt == LEB_EXP + 1, "R8", cnt, LEB_EXP + 1);
    chk(LEB_EXP == 22, "R10", LEB_EXP, 22);
    outs4("R9", 4'b0101);
    hso = 1'b0;
    tick();
    outs4("R9", 4'b0100);
    repeat (3) tick();
    outs4("R9", 4'b0100);
    pwm = 1'b0;
    tick();
    outs4("R9", 4'b0100);
    pwm = 1'b1;
    tick();
    outs4("R9", 4'b1000);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule